// File: doc/BRIEF.md
# Keyed Pin Lock Register Bank

This block keeps a lock flag for every pin of a pin controller, organised as up to eight banks of 32 pins. Other configuration logic reads the flattened lock vector and refuses to change a pin whose flag is set. Software reaches the flags through a plain register bus with a one-cycle write strobe, a byte address, write data and combinational read data.

A bank word cannot be changed by a single write. Software must first write a fixed key to a password register, which arms the block. The very next bus write, if it targets a bank lock word, is taken. Any write resets the armed state, except a write of the key to the password register. Lock words read back, so software can flip single pins with read, modify, key, write.

Top module: `pin_lock_regs`

## Requirements
- R1: While rst_n is low at a clock edge, every lock bit becomes 1 and the block is disarmed. After reset every bank word reads 32'hFFFF_FFFF.
- R2: A write of 32'h00A5_A501 to byte address 0x520 arms the block. If the next write targets bank b's word at 0x500 + 4*b, that word takes the write data from the following clock edge.
- R3: A write to a bank word while disarmed is ignored, and the word reads back unchanged.
- R4: Every write to a bank word disarms the block, so a second bank write with no new key is ignored.
- R5: A write of any other value to 0x520 disarms the block.
- R6: A write to any other address disarms the block. This includes addresses of banks beyond NUM_BANKS.
- R7: rdata shows the addressed bank word combinationally. Address 0x520, unused bank addresses and all other addresses read 0.
- R8: lock_vec[32*b + p] is the lock bit of pin p in bank b. A value of 1 means locked and 0 means unlocked.
- R9: A granted write changes only the addressed bank. The other banks keep their values.
- R10: Cycles without a write leave the armed state and all lock words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| lock_vec | output | NUM_BANKS*32 | Per-pin lock flags, 1 = locked |

## Verification
The bench builds the block with NUM_BANKS = 3 and the default 12-bit address. With that setting the bank slot at 0x50C lies beyond the implemented banks. The bench can then show that this slot reads 0 and behaves as an unrelated address: a write there between the key and a real bank write cancels the grant. The remaining tests cover bank isolation and the exact bit positions in lock_vec across three banks.

// File: rtl/pin_lock_pkg.sv
// Package: shared word type and fixed constants of the keyed pin lock block.
// Assumes the lock words and the key are 32 bits wide.
package pin_lock_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MAX_BANKS = 8;
    typedef logic [WORD_W-1:0] word_t;
    localparam word_t ALL_LOCKED = '1;
endpackage

// File: rtl/pin_lock_decode.sv
// Address decoder: flags a hit on the password register and on each
// implemented bank lock word. Assumes exact byte addresses (word aligned).
module pin_lock_decode #(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h520,
    parameter logic [ADDR_W-1:0] LOCK_BASE = 12'h500
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 key_hit,
    output logic [NUM_BANKS-1:0] bank_hit
);
    // Password register address compare.
    assign key_hit = (addr == KEY_ADDR);

    // One compare per implemented bank word.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
        localparam logic [ADDR_W-1:0] BANK_ADDR = LOCK_BASE + ADDR_W'(4 * b);
        assign bank_hit[b] = (addr == BANK_ADDR);
    end
endmodule

// File: rtl/pin_lock_arm.sv
// Arming flop: set by a key write to the password register, cleared by
// every other write, held while the bus is idle. Assumes one write per strobe.
module pin_lock_arm #(
    parameter logic [31:0] KEY = 32'h00A5_A501
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        key_hit,
    input  logic [31:0] wdata,
    output logic        armed
);
    // Track whether the previous write was the key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr_en) begin
            armed <= key_hit && (wdata == KEY);
        end
    end
endmodule

// File: rtl/pin_lock_bank.sv
// One bank lock word: loads on a granted write, resets to all locked.
// Assumes load is already qualified by the arming state.
module pin_lock_bank
    import pin_lock_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t wdata,
    output word_t word
);
    // Hold or replace the bank's lock bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= ALL_LOCKED;
        end else if (load) begin
            word <= wdata;
        end
    end
endmodule

// File: rtl/pin_lock_regs.sv
// Keyed pin lock register bank (top). Holds NUM_BANKS lock words of 32 pins.
// A bank word changes only on the write that immediately follows the key
// write to the password register. Assumes 1 <= NUM_BANKS <= 8.
module pin_lock_regs
    import pin_lock_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h520,
    parameter logic [ADDR_W-1:0] LOCK_BASE = 12'h500,
    parameter logic [31:0]       KEY       = 32'h00A5_A501
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NUM_BANKS*WORD_W-1:0] lock_vec
);
    localparam int unsigned VEC_W = NUM_BANKS * WORD_W;

    logic                 key_hit;
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 armed_q;
    word_t                words [NUM_BANKS];

    pin_lock_decode #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
        .KEY_ADDR(KEY_ADDR), .LOCK_BASE(LOCK_BASE)
    ) u_dec (
        .addr(addr), .key_hit(key_hit), .bank_hit(bank_hit)
    );

    pin_lock_arm #(.KEY(KEY)) u_arm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .key_hit(key_hit), .wdata(wdata), .armed(armed_q)
    );

    // One register per bank, loaded only on an armed write to its address.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pin_lock_bank u_bank (
            .clk(clk), .rst_n(rst_n),
            .load(wr_en && armed_q && bank_hit[b]),
            .wdata(wdata), .word(words[b])
        );
        assign lock_vec[b*WORD_W +: WORD_W] = words[b];
    end

    // Read mux: addressed bank word, zero elsewhere.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) rdata = words[b];
        end
    end

    logic unused_w;
    assign unused_w = (VEC_W == 0);
endmodule

// File: rtl/pin_lock_chk.sv
// Checker for pin_lock_regs: protocol properties on the arming state,
// the lock vector and the read port. Bound to every instance of the top.
module pin_lock_chk #(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h520,
    parameter logic [ADDR_W-1:0] LOCK_BASE = 12'h500,
    parameter logic [31:0]       KEY       = 32'h00A5_A501
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [31:0]               wdata,
    input logic [31:0]               rdata,
    input logic                      armed,
    input logic [NUM_BANKS*32-1:0]   lock_vec
);
    logic in_bank;
    assign in_bank = (addr >= LOCK_BASE) && (addr[1:0] == 2'b00) &&
                     ({20'd0, addr} < {20'd0, LOCK_BASE} + 32'(4 * NUM_BANKS));

    // R1
    reset_locked_chk: assert property (@(posedge clk)
        !rst_n |=> (&lock_vec) && !armed);
    // R2
    key_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == KEY_ADDR && wdata == KEY) |=> armed);
    // R3
    disarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(lock_vec));
    // R4
    bank_write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_bank) |=> !armed);
    // R5
    bad_key_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == KEY_ADDR && wdata != KEY) |=> !armed);
    // R7
    key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == KEY_ADDR) |-> (rdata == 32'd0));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(armed) && $stable(lock_vec));
endmodule

bind pin_lock_regs pin_lock_chk #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR),
    .LOCK_BASE(LOCK_BASE), .KEY(KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .armed(armed_q), .lock_vec(lock_vec)
);

// File: tb/pin_lock_regs_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected words, a monitor compares them.
module pin_lock_regs_tb;
    localparam int unsigned NB = 3;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    typedef struct {
        logic [11:0] a;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NB*32-1:0]  lock_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    item_t sb[$];
    event  ev_sample;

    always #2.5 clk = ~clk;

    pin_lock_regs #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lock_vec(lock_vec)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock_key();
        wr(12'h520, KEY);
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        addr = a;
        #1;
        it.a = a; it.exp = e; it.tag = t;
        sb.push_back(it);
        ->ev_sample;
        #0.5;
    endtask

    // Monitor: pop each expected item, compare rdata and the lock_vec slice.
    initial begin
        forever begin
            @(ev_sample);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s rdata @%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
                end
                if (it.a >= 12'h500 && it.a < 12'h500 + 4 * NB) begin
                    int b;
                    b = (int'(it.a) - 'h500) / 4;
                    checks++;
                    if (lock_vec[b*32 +: 32] !== it.exp) begin
                        failures++;
                        $display("FAIL R8 lock_vec bank %0d actual=%h expected=%h",
                                 b, lock_vec[b*32 +: 32], it.exp);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R8 slices
        for (int b = 0; b < NB; b++) expect_rd(12'h500 + 12'(4*b), 32'hFFFF_FFFF, "R1");
        // R7 password and unused bank slot read zero
        expect_rd(12'h520, 32'h0, "R7");
        expect_rd(12'h50C, 32'h0, "R7");
        // R3 write without key ignored
        wr(12'h500, 32'h0);
        expect_rd(12'h500, 32'hFFFF_FFFF, "R3");
        // R2 keyed write to bank 1, R9 others intact
        unlock_key();
        wr(12'h504, 32'h0000_F00F);
        expect_rd(12'h504, 32'h0000_F00F, "R2");
        expect_rd(12'h500, 32'hFFFF_FFFF, "R9");
        expect_rd(12'h508, 32'hFFFF_FFFF, "R9");
        // R4 second write without fresh key ignored
        wr(12'h504, 32'h0);
        expect_rd(12'h504, 32'h0000_F00F, "R4");
        // R5 wrong key disarms
        unlock_key();
        wr(12'h520, 32'h00A5_A500);
        wr(12'h508, 32'h0);
        expect_rd(12'h508, 32'hFFFF_FFFF, "R5");
        // R6 unrelated address disarms
        unlock_key();
        wr(12'h400, 32'h1);
        wr(12'h508, 32'h0);
        expect_rd(12'h508, 32'hFFFF_FFFF, "R6");
        // R6 unimplemented bank slot disarms and stays zero
        unlock_key();
        wr(12'h50C, 32'h0);
        wr(12'h508, 32'h0);
        expect_rd(12'h508, 32'hFFFF_FFFF, "R6");
        expect_rd(12'h50C, 32'h0, "R6");
        // R10 idle cycles keep the armed state
        unlock_key();
        repeat (5) @(negedge clk);
        wr(12'h508, 32'h1234_5678);
        expect_rd(12'h508, 32'h1234_5678, "R10");
        // R2 read-modify-write of one pin in bank 1
        unlock_key();
        wr(12'h504, 32'h0000_F00F | 32'h10);
        expect_rd(12'h504, 32'h0000_F01F, "R2");
        // R1 reset mid-run relocks every bank
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int b = 0; b < NB; b++) expect_rd(12'h500 + 12'(4*b), 32'hFFFF_FFFF, "R1");
        // R1 reset also disarms: a bare bank write is ignored
        wr(12'h500, 32'h0);
        expect_rd(12'h500, 32'hFFFF_FFFF, "R1");
        @(negedge clk);
        finish_run();
    end
endmodule